// File: doc/BRIEF.md
# Berger Code Encoder and Unidirectional Error Checker

This block protects a parallel information word with a Berger check field. The encode path counts the zero bits of the information word and issues that count as the check field, next to the unchanged information bits. The code is separable, so a receiver reads the information bits as they are and needs no decoding step.

The check path takes an information word and its check field. It counts the zeros in the received information bits again and compares that count with the received check field. A fault that only turns 1s into 0s raises the zero count of the information bits and can only lower the value in the check field. A fault that only turns 0s into 1s does the opposite. Either kind of fault therefore always causes a mismatch.

The verdict comes out on a two-rail pair, not on a single flag. A no-error pair alternates between its two legal values from one word to the next, so a rail stuck at either level shows up as an error code within two words. Each path has a valid strobe and a latency of one registered cycle.

Top module: `berger_codec`

## Requirements
- R1: The check field is ceil(log2(INFO_W+1)) bits wide. With the default INFO_W = 8 it is 4 bits wide.
- R2: One cycle after `enc_valid_i` is high, `enc_check_o` holds the binary count of 0 bits in the `enc_data_i` that was presented.
- R3: `enc_valid_o` repeats `enc_valid_i` one cycle later. `enc_data_o` repeats the presented information word unchanged.
- R4: `chk_valid_o` repeats `chk_valid_i` one cycle later. `chk_data_o` repeats the received information bits unchanged.
- R5: When the received check field equals the zero count of the received information bits, `chk_rail_o` is 2'b01 or 2'b10.
- R6: Any mismatch between the received check field and the recomputed zero count forces `chk_rail_o` to 2'b00 or 2'b11. This covers every purely unidirectional corruption of the information bits, the check field, or both.
- R7: Bit 0 of `chk_rail_o` is 1 on the first checked word after reset and inverts on every later checked word, whatever the verdict. On a good word the pair is 01 when bit 0 is 1 and 10 when bit 0 is 0. On a bad word it is 11 when bit 0 is 1 and 00 when bit 0 is 0.
- R8: While `rst_n` is low, both valid outputs are 0, the data and check outputs are 0, and `chk_rail_o` is 2'b10.
- R9: In a cycle that follows a cycle with no valid input, the output registers of that path keep their previous values. This applies to the rails as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Information word to encode is present |
| enc_data_i | input | INFO_W | Information word to encode |
| enc_valid_o | output | 1 | Encoded word is present |
| enc_data_o | output | INFO_W | Information bits of the encoded word |
| enc_check_o | output | CHK_W | Zero-count check field |
| chk_valid_i | input | 1 | Received word to check is present |
| chk_data_i | input | INFO_W | Received information bits |
| chk_check_i | input | CHK_W | Received check field |
| chk_valid_o | output | 1 | Verdict is present |
| chk_data_o | output | INFO_W | Received information bits, passed through |
| chk_rail_o | output | 2 | Two-rail verdict: 01/10 good, 00/11 error |

## Verification
The hardest situation to reach is one where the expected rail value depends on how many words came before it. An error on an even-numbered word must give 11, and an error on an odd-numbered word must give 00. A stuck rail only shows up when the legal phase and the faulty value differ. The bench therefore keeps its own count of words since reset. It sends a mix of good and bad words through both the stimulus table and a back-to-back burst. As a result, both error codes and both good codes appear, including pairs of words in adjacent cycles. Unidirectional faults are modelled by clearing set bits or setting clear bits of a valid codeword, in both the information bits and the check field.

// File: rtl/berger_pkg.sv
package berger_pkg;

  // Width of the zero-count field for a given information width.
  function automatic int check_width(input int info_w);
    return $clog2(info_w + 1);
  endfunction

  // Two-rail verdict from the phase bit (rail 0) and the match result.
  // A good word gives complementary rails, a bad word gives equal rails.
  function automatic logic [1:0] rail_pair(input logic phase_bit, input logic match);
    logic upper;
    upper = match ? ~phase_bit : phase_bit;
    return {upper, phase_bit};
  endfunction

endpackage

// File: rtl/berger_zero_counter.sv
module berger_zero_counter #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  word_i,
  output logic [CW-1:0] zeros_o
);

  // Ripple of partial sums, one stage per information bit.
  logic [CW-1:0] partial [W+1];

  assign partial[0] = '0;

  for (genvar g = 0; g < W; g++) begin : g_stage
    assign partial[g+1] = partial[g] + CW'(~word_i[g]);
  end

  assign zeros_o = partial[W];

endmodule

// File: rtl/berger_encoder.sv
module berger_encoder #(
  parameter int INFO_W = 8,
  parameter int CHK_W  = $clog2(INFO_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [INFO_W-1:0] data_i,
  output logic              valid_o,
  output logic [INFO_W-1:0] data_o,
  output logic [CHK_W-1:0]  check_o
);

  logic [CHK_W-1:0] zeros_now;

  berger_zero_counter #(.W(INFO_W), .CW(CHK_W)) u_count (
    .word_i  (data_i),
    .zeros_o (zeros_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      check_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o  <= data_i;
        check_o <= zeros_now;
      end
    end
  end

endmodule

// File: rtl/berger_checker.sv
module berger_checker
  import berger_pkg::*;
#(
  parameter int INFO_W = 8,
  parameter int CHK_W  = $clog2(INFO_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [INFO_W-1:0] data_i,
  input  logic [CHK_W-1:0]  check_i,
  output logic              valid_o,
  output logic [INFO_W-1:0] data_o,
  output logic [1:0]        rail_o,
  output logic              mismatch_o
);

  logic [CHK_W-1:0] zeros_seen;
  logic             phase_q;

  berger_zero_counter #(.W(INFO_W), .CW(CHK_W)) u_count (
    .word_i  (data_i),
    .zeros_o (zeros_seen)
  );

  assign mismatch_o = (zeros_seen != check_i);

  // phase_q is the value that rail 0 takes on the next checked word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      rail_o  <= 2'b10;
      phase_q <= 1'b1;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o  <= data_i;
        rail_o  <= rail_pair(phase_q, ~mismatch_o);
        phase_q <= ~phase_q;
      end
    end
  end

endmodule

// File: rtl/berger_codec.sv
module berger_codec #(
  parameter int INFO_W = 8,
  parameter int CHK_W  = $clog2(INFO_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_valid_i,
  input  logic [INFO_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [INFO_W-1:0] enc_data_o,
  output logic [CHK_W-1:0]  enc_check_o,
  input  logic              chk_valid_i,
  input  logic [INFO_W-1:0] chk_data_i,
  input  logic [CHK_W-1:0]  chk_check_i,
  output logic              chk_valid_o,
  output logic [INFO_W-1:0] chk_data_o,
  output logic [1:0]        chk_rail_o
);

  // Comparator result, brought out by name for the property checker.
  logic chk_mismatch;

  berger_encoder #(.INFO_W(INFO_W), .CHK_W(CHK_W)) u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (enc_valid_i),
    .data_i  (enc_data_i),
    .valid_o (enc_valid_o),
    .data_o  (enc_data_o),
    .check_o (enc_check_o)
  );

  berger_checker #(.INFO_W(INFO_W), .CHK_W(CHK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (chk_valid_i),
    .data_i     (chk_data_i),
    .check_i    (chk_check_i),
    .valid_o    (chk_valid_o),
    .data_o     (chk_data_o),
    .rail_o     (chk_rail_o),
    .mismatch_o (chk_mismatch)
  );

endmodule

// File: rtl/berger_codec_props.sv
module berger_codec_props #(
  parameter int INFO_W = 8,
  parameter int CHK_W  = $clog2(INFO_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enc_valid_i,
  input logic [INFO_W-1:0] enc_data_i,
  input logic              enc_valid_o,
  input logic [INFO_W-1:0] enc_data_o,
  input logic [CHK_W-1:0]  enc_check_o,
  input logic              chk_valid_i,
  input logic [INFO_W-1:0] chk_data_i,
  input logic [CHK_W-1:0]  chk_check_i,
  input logic              chk_valid_o,
  input logic [INFO_W-1:0] chk_data_o,
  input logic [1:0]        chk_rail_o,
  input logic              chk_mismatch
);

  // Rail 0 of the most recent checked word (reset value of rails is 10).
  logic last_r0;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_r0 <= 1'b0;
    else if (chk_valid_o) last_r0 <= chk_rail_o[0];
  end

  initial assert_width_R1: assert (CHK_W == $clog2(INFO_W + 1));

  assert_zero_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid_o |-> (int'(enc_check_o) + $countones(enc_data_o)) == INFO_W);

  assert_enc_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid_i |=> enc_valid_o && enc_data_o == $past(enc_data_i));

  assert_chk_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_i |=> chk_valid_o && chk_data_o == $past(chk_data_i));

  assert_good_rails_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && !chk_mismatch) |=> chk_rail_o[1] != chk_rail_o[0]);

  assert_bad_rails_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_o && (int'($past(chk_check_i)) + $countones($past(chk_data_i))) != INFO_W
      |-> chk_rail_o[1] == chk_rail_o[0]);

  assert_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_o |-> chk_rail_o[0] != last_r0);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid_i |=> $stable(chk_rail_o) && $stable(chk_data_o));

endmodule

bind berger_codec berger_codec_props #(.INFO_W(INFO_W), .CHK_W(CHK_W)) u_props (
  .clk          (clk),
  .rst_n        (rst_n),
  .enc_valid_i  (enc_valid_i),
  .enc_data_i   (enc_data_i),
  .enc_valid_o  (enc_valid_o),
  .enc_data_o   (enc_data_o),
  .enc_check_o  (enc_check_o),
  .chk_valid_i  (chk_valid_i),
  .chk_data_i   (chk_data_i),
  .chk_check_i  (chk_check_i),
  .chk_valid_o  (chk_valid_o),
  .chk_data_o   (chk_data_o),
  .chk_rail_o   (chk_rail_o),
  .chk_mismatch (chk_mismatch)
);

// File: tb/berger_codec_tb.sv
module berger_codec_tb;

  localparam int INFO_W = 8;
  localparam int CHK_W  = 4;
  localparam int NVEC   = 12;

  // Entry: {information bits[12:5], check field[4:1], expected good[0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {8'h00, 4'd8,  1'b1},
    {8'hFF, 4'd0,  1'b1},
    {8'h45, 4'd5,  1'b1},
    {8'h45, 4'd4,  1'b0},   // check 5 -> 4: a set bit cleared
    {8'hA5, 4'd4,  1'b1},
    {8'h25, 4'd4,  1'b0},   // A5 -> 25: a set info bit cleared
    {8'h0F, 4'd4,  1'b1},
    {8'h0F, 4'd15, 1'b0},   // check 4 -> 15: clear bits set
    {8'h80, 4'd7,  1'b1},
    {8'h00, 4'd0,  1'b0},   // FF/0 with all info bits cleared
    {8'hFF, 4'd8,  1'b0},   // 00/8 with all info bits set
    {8'h3C, 4'd4,  1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enc_valid_i = 1'b0;
  logic [INFO_W-1:0] enc_data_i = '0;
  logic              enc_valid_o;
  logic [INFO_W-1:0] enc_data_o;
  logic [CHK_W-1:0]  enc_check_o;
  logic              chk_valid_i = 1'b0;
  logic [INFO_W-1:0] chk_data_i = '0;
  logic [CHK_W-1:0]  chk_check_i = '0;
  logic              chk_valid_o;
  logic [INFO_W-1:0] chk_data_o;
  logic [1:0]        chk_rail_o;

  int checks = 0;
  int errors = 0;
  int word_n = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  berger_codec #(.INFO_W(INFO_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
    .enc_valid_o(enc_valid_o), .enc_data_o(enc_data_o), .enc_check_o(enc_check_o),
    .chk_valid_i(chk_valid_i), .chk_data_i(chk_data_i), .chk_check_i(chk_check_i),
    .chk_valid_o(chk_valid_o), .chk_data_o(chk_data_o), .chk_rail_o(chk_rail_o)
  );

  // Zero count restated by shifting the word out bit by bit.
  function automatic int zeros_of(input logic [INFO_W-1:0] w);
    int n = 0;
    logic [INFO_W-1:0] t = w;
    repeat (INFO_W) begin
      if (t[0] == 1'b0) n++;
      t = t >> 1;
    end
    return n;
  endfunction

  // Rails expected for word number n (counted from 0 since reset).
  function automatic logic [1:0] rails_for(input int n, input bit good);
    if (n % 2 == 0) return good ? 2'b01 : 2'b11;
    return good ? 2'b10 : 2'b00;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic encode_one(input logic [INFO_W-1:0] d);
    @(negedge clk);
    enc_valid_i = 1'b1; enc_data_i = d;
    @(negedge clk);
    enc_valid_i = 1'b0;
    check("R2 check field", int'(enc_check_o), zeros_of(d));
    check("R3 data", int'(enc_data_o), int'(d));
    check("R3 valid", int'(enc_valid_o), 1);
  endtask

  task automatic check_one(input logic [INFO_W-1:0] d, input logic [CHK_W-1:0] c, input bit good);
    @(negedge clk);
    chk_valid_i = 1'b1; chk_data_i = d; chk_check_i = c;
    @(negedge clk);
    chk_valid_i = 1'b0;
    check("R4 data", int'(chk_data_o), int'(d));
    check("R4 valid", int'(chk_valid_o), 1);
    check(good ? "R5 rails" : "R6 rails", int'(chk_rail_o), int'(rails_for(word_n, good)));
    word_n++;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] held;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 enc_valid_o", int'(enc_valid_o), 0);
    check("R8 chk_valid_o", int'(chk_valid_o), 0);
    check("R8 enc_check_o", int'(enc_check_o), 0);
    check("R8 rails", int'(chk_rail_o), 2);
    check("R1 width", $bits(enc_check_o), 4);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: encoder on each information word, checker on each pair
    for (int i = 0; i < NVEC; i++) begin
      encode_one(VEC[i][12:5]);
      check_one(VEC[i][12:5], VEC[i][4:1], VEC[i][0]);
    end

    // R9: idle cycles keep outputs
    held = chk_rail_o;
    repeat (3) @(negedge clk);
    check("R9 rails held", int'(chk_rail_o), int'(held));
    check("R9 chk_valid_o low", int'(chk_valid_o), 0);
    check("R9 enc_check held", int'(enc_check_o), zeros_of(VEC[NVEC-1][12:5]));

    // R7: back-to-back burst, bad/good/bad/good
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i > 0)
        check("R7 burst rails", int'(chk_rail_o), int'(rails_for(word_n - 1, (i % 2) == 0)));
      chk_valid_i = 1'b1;
      chk_data_i  = 8'hF0;
      chk_check_i = (i % 2 == 0) ? 4'd3 : 4'd4;
      word_n++;
    end
    @(negedge clk);
    chk_valid_i = 1'b0;
    check("R7 burst last", int'(chk_rail_o), int'(rails_for(word_n - 1, 1'b1)));

    // Reset again: R7 phase restarts at 01
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 rails after reset", int'(chk_rail_o), 2);
    rst_n = 1'b1;
    word_n = 0;
    check_one(8'h55, 4'd4, 1'b1);
    check_one(8'h55, 4'd4, 1'b1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule